// File: doc/BRIEF.md
# SPI Transfer Core with Status Flag Handshake

This block is an 8-bit SPI transfer engine with a small CPU register window. The window has a control register, a read-only status register and a data register. In master mode, writing the data register launches a byte and generates SCK. In slave mode, the byte is clocked by an external master while the select input is low. At the end of every byte, the received value is latched into a receive buffer and a completion flag is raised. That flag can drive an interrupt line.

Software manages the flags with a two-step handshake. It first reads the status register while a flag is set, which arms the flag. A later data-register access then clears it. A data write made while a byte is in flight is rejected and reported through a collision flag, and the byte already on the wire finishes unchanged. When a slave keeps receiving bytes before software has cleared the completion flag, the buffer holds on to the first of those bytes.

Register select on `addr_i`: 0 is control (bit 0 enables the interrupt, bit 1 selects master), 1 is status, 2 is data.

Top module: `spi_flag_unit`

## Requirements
- R1: After reset, status and control read 0x00, `irq_o` is low and `sck_o` is low.
- R2: The status register has this layout: bit 7 is the completion flag, bit 6 is the collision flag and bit 4 is a reserved mode-fault bit that reads 0. All other bits read 0. Writes to the status register have no effect.
- R3: At the end of a byte, the completion flag sets, and in that same clock the shift register is copied into the receive buffer. A data-register read returns that buffer.
- R4: `irq_o` is high exactly while the completion flag is set and control bit 0 is 1. A set collision flag never raises `irq_o`.
- R5: The completion flag clears only when the status register has been read with the flag set and a data read or data write follows. A data access made without that prior status read leaves the flag set.
- R6: In master mode, a data write while idle starts a byte. The byte goes out MSB first in SPI mode 0: SCK idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge. Each SCK half period lasts HALF_DIV clocks.
- R7: In master mode, while the completion flag is set and not yet armed by a status read, a data write is ignored and no SCK edge follows.
- R8: A data write while a byte is active sets the collision flag and is discarded. The active byte continues unchanged.
- R9: The collision flag clears after a status read with the flag set, followed by a data read before completion, or by a data read or write after completion. A data write made before completion sets the flag again.
- R10: In slave mode with `ss_ni` low, MOSI is sampled on the rising edge of `sck_i` and the byte shifts on the falling edge. `miso_o` presents the byte preloaded by a data write made while `ss_ni` was high, MSB first.
- R11: If a slave completes more bytes while the completion flag is still set, the receive buffer keeps the first byte and discards the later ones.
- R12: A data read during an active byte has no effect on the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master serial data out |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Slave serial clock |
| mosi_i | input | 1 | Slave serial data in |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Slave serial data out |
| irq_o | output | 1 | Interrupt request |

## Verification
The two functions that can act in the same cycle are collision detection on a data write and the shifter stepping through a byte. The bench provokes this by issuing the rejected write at a different bit position in each pass of a sweep, sometimes on the very cycle SCK toggles. It judges the outcome by the byte captured from MOSI, which must equal the first write, and by the collision and completion bits read before and after the end of the byte. A second overlap, a status read that arms both flags at once followed by a single data read that clears both, is judged on the status value read back afterwards.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  localparam int unsigned CTRL_IEN_BIT = 0;
  localparam int unsigned CTRL_MST_BIT = 1;
endpackage

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] shreg_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam int unsigned DIV_W = $clog2(HALF_DIV);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DIV_W-1:0]  div_q;
  logic              sck_m_q, busy_m_q, done_q, rx_bit_q, sck_s_q;
  logic              slv_rise, slv_fall;

  assign slv_rise = !ss_ni &&  sck_i && !sck_s_q;
  assign slv_fall = !ss_ni && !sck_i &&  sck_s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      div_q    <= '0;
      sck_m_q  <= 1'b0;
      busy_m_q <= 1'b0;
      done_q   <= 1'b0;
      rx_bit_q <= 1'b0;
      sck_s_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      sck_s_q <= sck_i;
      if (master_i) begin
        if (start_i) begin
          shreg_q  <= tx_i;
          busy_m_q <= 1'b1;
          cnt_q    <= '0;
          div_q    <= '0;
          sck_m_q  <= 1'b0;
        end else if (busy_m_q) begin
          if (div_q == DIV_W'(HALF_DIV-1)) begin
            div_q   <= '0;
            sck_m_q <= ~sck_m_q;
            if (!sck_m_q) begin
              rx_bit_q <= miso_i;
            end else begin
              shreg_q <= {shreg_q[DATA_W-2:0], rx_bit_q};
              cnt_q   <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(DATA_W-1)) begin
                busy_m_q <= 1'b0;
                done_q   <= 1'b1;
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
      end else begin
        if (start_i) shreg_q <= tx_i;
        if (ss_ni) begin
          cnt_q <= '0;
        end else if (slv_rise) begin
          rx_bit_q <= mosi_i;
        end else if (slv_fall) begin
          shreg_q <= {shreg_q[DATA_W-2:0], rx_bit_q};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W-1)) done_q <= 1'b1;
        end
      end
    end
  end

  assign sck_o   = sck_m_q;
  assign sdo_o   = shreg_q[DATA_W-1];
  assign busy_o  = master_i ? busy_m_q : !ss_ni;
  assign done_o  = done_q;
  assign shreg_o = shreg_q;

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_sck_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_m_q) |-> !sck_m_q);
endmodule

// File: rtl/spi_flags.sv
module spi_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] shreg_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  input  logic              data_wr_i,
  output logic              cmpl_o,
  output logic              coll_o,
  output logic              load_o,
  output logic [DATA_W-1:0] rxbuf_o
);
  logic              cmpl_q, cmpl_arm_q, coll_q, coll_arm_q;
  logic [DATA_W-1:0] rxbuf_q;
  logic              cmpl_clr, coll_clr, coll_set, wr_block;

  assign cmpl_clr = cmpl_arm_q && (data_rd_i || data_wr_i);
  assign coll_clr = coll_arm_q && (data_rd_i || (data_wr_i && cmpl_q));
  assign coll_set = data_wr_i && busy_i;
  assign wr_block = master_i && cmpl_q && !cmpl_arm_q;
  assign load_o   = data_wr_i && !busy_i && !wr_block;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmpl_q     <= 1'b0;
      cmpl_arm_q <= 1'b0;
      rxbuf_q    <= '0;
    end else if (done_i) begin
      cmpl_q     <= 1'b1;
      cmpl_arm_q <= 1'b0;
      if (!cmpl_q || cmpl_clr) rxbuf_q <= shreg_i;
    end else if (cmpl_clr) begin
      cmpl_q     <= 1'b0;
      cmpl_arm_q <= 1'b0;
    end else if (stat_rd_i && cmpl_q) begin
      cmpl_arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coll_q     <= 1'b0;
      coll_arm_q <= 1'b0;
    end else if (coll_set) begin
      coll_q     <= 1'b1;
      coll_arm_q <= 1'b0;
    end else if (coll_clr) begin
      coll_q     <= 1'b0;
      coll_arm_q <= 1'b0;
    end else if (stat_rd_i && coll_q) begin
      coll_arm_q <= 1'b1;
    end
  end

  assign cmpl_o  = cmpl_q;
  assign coll_o  = coll_q;
  assign rxbuf_o = rxbuf_q;

  assert_cmpl_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> cmpl_q);
  assert_cmpl_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmpl_q) |-> $past(cmpl_arm_q && (data_rd_i || data_wr_i)));
  assert_buf_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && cmpl_q && !cmpl_clr) |=> $stable(rxbuf_q));
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_flag_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              miso_o,
  output logic              irq_o
);
  logic              ien_q, mst_q;
  logic              stat_rd, data_rd, data_wr, load;
  logic              busy, done, cmpl, coll, sdo;
  logic [DATA_W-1:0] shreg, rxbuf, stat_w;

  assign stat_rd = rd_i && (addr_i == SEL_STAT);
  assign data_rd = rd_i && (addr_i == SEL_DATA);
  assign data_wr = wr_i && (addr_i == SEL_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= 1'b0;
      mst_q <= 1'b0;
    end else if (wr_i && addr_i == SEL_CTRL) begin
      ien_q <= wdata_i[CTRL_IEN_BIT];
      mst_q <= wdata_i[CTRL_MST_BIT];
    end
  end

  spi_shifter #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) i_shifter (
    .clk_i, .rst_ni,
    .master_i (mst_q),
    .start_i  (load),
    .tx_i     (wdata_i),
    .miso_i, .sck_i, .mosi_i, .ss_ni,
    .sck_o,
    .sdo_o    (sdo),
    .busy_o   (busy),
    .done_o   (done),
    .shreg_o  (shreg)
  );

  spi_flags #(.DATA_W(DATA_W)) i_flags (
    .clk_i, .rst_ni,
    .master_i  (mst_q),
    .busy_i    (busy),
    .done_i    (done),
    .shreg_i   (shreg),
    .stat_rd_i (stat_rd),
    .data_rd_i (data_rd),
    .data_wr_i (data_wr),
    .cmpl_o    (cmpl),
    .coll_o    (coll),
    .load_o    (load),
    .rxbuf_o   (rxbuf)
  );

  // mode-fault bit (DATA_W-4) reserved, reads 0
  always_comb begin
    stat_w           = '0;
    stat_w[DATA_W-1] = cmpl;
    stat_w[DATA_W-2] = coll;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      SEL_CTRL: begin
        rdata_o[CTRL_IEN_BIT] = ien_q;
        rdata_o[CTRL_MST_BIT] = mst_q;
      end
      SEL_STAT: rdata_o = stat_w;
      SEL_DATA: rdata_o = rxbuf;
      default:  rdata_o = '0;
    endcase
  end

  assign mosi_o = sdo;
  assign miso_o = sdo;
  assign irq_o  = cmpl && ien_q;

  assert_coll_on_busy_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && busy) |=> coll);
  assert_busy_wr_no_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && busy && mst_q) |=> busy);
endmodule

// File: tb/test_spi_flag_unit.sv
module test_spi_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       sck_o, mosi_o, miso_i, miso_o, irq_o;
  logic       sck_s = 1'b0, mosi_s = 1'b0, ss_n = 1'b1;

  int checks = 0, errors = 0;
  int rise_cnt = 0, fall_cnt = 0, base = 0;
  logic [7:0] cap = '0, rsp = '0;
  logic [2:0] ridx;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flag_unit #(.DATA_W(8), .HALF_DIV(HALF)) i_spi_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd_en), .wr_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .sck_i(sck_s), .mosi_i(mosi_s), .ss_ni(ss_n),
    .miso_o(miso_o), .irq_o(irq_o)
  );

  // bench-side slave responder for master mode
  always @(posedge sck_o) begin cap <= {cap[6:0], mosi_o}; rise_cnt++; end
  always @(negedge sck_o) fall_cnt++;
  assign ridx   = 3'(7 - (fall_cnt - base));
  assign miso_i = rsp[ridx];

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq_o && n < 500) begin @(negedge clk); n++; end
    chk(tag, 8'(irq_o), 8'h01);
  endtask

  task automatic slv_xfer(input logic [7:0] b, output logic [7:0] got);
    ss_n = 1'b0; cyc(4);
    for (int k = 7; k >= 0; k--) begin
      mosi_s = b[k]; cyc(HALF);
      sck_s = 1'b1; got = {got[6:0], miso_o}; cyc(HALF);
      sck_s = 1'b0;
    end
    cyc(HALF); ss_n = 1'b1; cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary(); $finish;
  end

  initial begin
    logic [7:0] d, tx, rx, got;
    int rc;
    cyc(3); rst_n = 1'b1; cyc(2);

    rd(2'd1, d); chk("R1 status after reset", d, 8'h00);
    rd(2'd0, d); chk("R1 control after reset", d, 8'h00);
    chk("R1 irq after reset", 8'(irq_o), 8'h00);
    chk("R1 sck idle", 8'(sck_o), 8'h00);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 status write ignored", d, 8'h00);

    wr(2'd0, 8'h03);
    rd(2'd0, d); chk("R1 control readback", d, 8'h03);

    // master sweep
    for (int i = 0; i < 16; i++) begin
      tx = 8'(i * 8'h1D) ^ 8'h5A;
      rx = 8'(i * 8'h37) + 8'h11;
      rsp = rx; base = fall_cnt;
      wr(2'd2, tx);
      cyc(2 * HALF * 3);
      rd(2'd2, d);                          // R12 read mid-byte
      chk("R4 no irq mid-byte", 8'(irq_o), 8'h00);
      wait_irq("R4 irq on completion");
      chk("R6 R12 mosi byte", cap, tx);
      rd(2'd1, d); chk("R2 R3 status after completion", d, 8'h80);
      rd(2'd2, d); chk("R3 rx buffer", d, rx);
      rd(2'd1, d); chk("R5 flag cleared", d, 8'h00);
      chk("R4 irq dropped", 8'(irq_o), 8'h00);
    end

    // collision at varying bit positions
    for (int j = 0; j < 8; j++) begin
      tx = 8'(j * 8'h4B) ^ 8'hC3;
      rx = ~tx;
      rsp = rx; base = fall_cnt;
      wr(2'd2, tx);
      cyc(j * 7 + 2);
      wr(2'd2, ~tx);                        // R8 rejected write
      rd(2'd1, d); chk("R8 collision flag", d, 8'h40);
      chk("R4 collision gives no irq", 8'(irq_o), 8'h00);
      if (j % 2 == 0) begin
        rd(2'd2, d);
        rd(2'd1, d); chk("R9 cleared by read before completion", d, 8'h00);
      end
      wait_irq("R8 byte completes");
      chk("R8 byte unchanged", cap, tx);
      rd(2'd1, d); chk("R9 status at completion", d, (j % 2 == 0) ? 8'h80 : 8'hC0);
      rd(2'd2, d); chk("R3 rx after collision", d, rx);
      rd(2'd1, d); chk("R9 R5 both cleared", d, 8'h00);
    end

    // collision re-set by write before completion
    rsp = 8'h96; base = fall_cnt;
    wr(2'd2, 8'h69); cyc(10);
    wr(2'd2, 8'h00);
    rd(2'd1, d); chk("R9 first collision", d, 8'h40);
    wr(2'd2, 8'h00);
    rd(2'd1, d); chk("R9 write before completion sets again", d, 8'h40);
    wait_irq("R9 byte completes");
    rd(2'd1, d); rd(2'd2, d); chk("R3 rx", d, 8'h96);
    rd(2'd1, d); chk("R9 cleared after completion", d, 8'h00);

    // ignored write while flag set and not armed
    rsp = 8'hA1; base = fall_cnt;
    wr(2'd2, 8'h1A); wait_irq("R6 byte done");
    rc = rise_cnt;
    wr(2'd2, 8'h3C); cyc(40);
    chk("R7 no SCK after blocked write", 8'(rise_cnt - rc), 8'h00);
    chk("R5 write without status read keeps flag", 8'(irq_o), 8'h01);
    rd(2'd2, d);
    chk("R5 read without status read keeps flag", 8'(irq_o), 8'h01);
    rd(2'd1, d); chk("R5 flag still set", d, 8'h80);
    rsp = 8'h5E; base = fall_cnt;
    wr(2'd2, 8'hE5);
    chk("R5 armed write clears flag", 8'(irq_o), 8'h00);
    wait_irq("R7 armed write starts byte");
    chk("R7 mosi byte after arming", cap, 8'hE5);
    rd(2'd1, d); rd(2'd2, d); chk("R3 rx", d, 8'h5E);

    // slave sweep
    wr(2'd0, 8'h01);
    for (int s = 0; s < 8; s++) begin
      tx = 8'(s * 8'h29) ^ 8'h81;
      rx = 8'(s * 8'h65) + 8'h07;
      wr(2'd2, tx);
      slv_xfer(rx, got);
      chk("R10 slave miso byte", got, tx);
      chk("R4 slave irq", 8'(irq_o), 8'h01);
      rd(2'd1, d); chk("R2 slave status", d, 8'h80);
      rd(2'd2, d); chk("R10 slave rx", d, rx);
      rd(2'd1, d); chk("R5 slave cleared", d, 8'h00);
    end

    // slave overrun
    wr(2'd2, 8'h11);
    slv_xfer(8'hB4, got);
    slv_xfer(8'h4B, got);
    slv_xfer(8'hE7, got);
    rd(2'd1, d); chk("R11 overrun status", d, 8'h80);
    rd(2'd2, d); chk("R11 first byte kept", d, 8'hB4);
    rd(2'd1, d); chk("R11 cleared", d, 8'h00);
    slv_xfer(8'h3D, got);
    rd(2'd1, d); rd(2'd2, d); chk("R11 next byte after clear", d, 8'h3D);

    summary();
    $finish;
  end
endmodule